// File: doc/BRIEF.md
# Flash Read-While-Write Access Controller

This block arbitrates bus reads into an embedded flash array while a program or erase operation is in flight. The array is split into blocks, and blocks are grouped into partitions. A program or erase only occupies the partition that holds its target address. Reads to any other partition are granted in the same cycle. A read that lands in the occupied partition is stalled, and the stall lasts until the operation is suspended or finishes.

Software starts an operation by setting the program or erase control bit. It then issues an interlock write to the array, which latches the target address, and for a program also the data word. Clearing the control bit completes the operation. A program can only clear bits, and an erase returns a whole block to all ones. Neither one changes a locked block or a block that does not exist.

Suspending either operation puts the array back into a read state where every read is served. Addresses inside nonexistent block slots decode normally to a partition. Reads there return a fixed filler word and raise no error.

Top module: `rww_flash_ctrl`

## Requirements
- R1: While `pgm_i`=1 and `psus_i`=1, every read request is granted (`rd_gnt_o`=1, `rd_stall_o`=0).
- R2: While `ers_i`=1, `esus_i`=1 and `pgm_i`=0, every read request is granted.
- R3: With a latched, unsuspended operation, a read whose partition differs from the partition of the operation's target is granted in the same cycle. With no interlock latched, no read is stalled.
- R4: A read to the partition of a latched, unsuspended operation gets `rd_stall_o`=1 and `rd_gnt_o`=0, and it produces no `rd_valid_o` on the next cycle.
- R5: The word address is {slot[2:0], word[3:0]}, with slot = addr[6:4]. By default, slots 0-1 form partition 0, slots 2-3 form partition 1, slots 4-5 form partition 2, and the nonexistent slots 6-7 form partition 3.
- R6: The first `wr_en_i` seen at a clock edge while `pgm_i`=1 latches a program interlock (address and data). The first one seen while `ers_i`=1 and `pgm_i`=0 latches an erase interlock. Later writes are ignored. `interlock_o` goes high after the latching edge and is cleared at the first edge where the owning bit is 0.
- R7: At the edge where `pgm_i` is 0 and a program interlock is latched, the target word becomes old AND data, but only when its block exists and its `lock_i` bit is 0 (1 = locked).
- R8: At the edge where `ers_i` is 0 and an erase interlock is latched, every word of the target block becomes all ones, but only when the block exists and is unlocked. On a shared edge, the erase is applied before the program.
- R9: A read to a nonexistent slot returns 32'hDEAD_BEEF. An interlock write there still raises `interlock_o`, and it still stalls reads to partition 3.
- R10: A granted read yields `rd_valid_o`=1 on the next cycle, with the array content from before that edge.
- R11: After reset, no interlock is latched, `rd_valid_o`=0, and every existing word reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pgm_i | input | 1 | Program operation bit |
| psus_i | input | 1 | Program suspend bit |
| ers_i | input | 1 | Erase operation bit |
| esus_i | input | 1 | Erase suspend bit |
| wr_en_i | input | 1 | Array (interlock) write strobe |
| wr_addr_i | input | 7 | Interlock write word address |
| wr_data_i | input | 32 | Interlock write data |
| lock_i | input | 6 | Per-block lock, 1 = locked |
| rd_req_i | input | 1 | Read request |
| rd_addr_i | input | 7 | Read word address |
| rd_gnt_o | output | 1 | Read granted this cycle |
| rd_stall_o | output | 1 | Read stalled by partition conflict |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| interlock_o | output | 1 | An interlock is latched |

## Verification
The bench targets reads that fall into the sibling block of the write target. A decoder that compared blocks instead of partitions would grant them, and the data returned would then be mid-update. It flips suspend bits in the middle of an operation, and it sets a program bit while an erase is suspended: a controller that kept its own busy flag would keep stalling, or would stall the wrong partition. Further directed cases cover a second write after the interlock, a commit into a locked or nonexistent block, and programming over zero bits. Designs that re-latch, write locked blocks or set bits back to one then return the wrong data on later reads.

// File: rtl/rww_pkg.sv
package rww_pkg;
  typedef enum logic {IL_PROG = 1'b0, IL_ERASE = 1'b1} il_kind_e;
  localparam logic [31:0] RWW_FILL = 32'hDEAD_BEEF;
endpackage

// File: rtl/rww_part_decode.sv
module rww_part_decode #(
  parameter int SLOT_W     = 3,
  parameter int NUM_BLOCKS = 6,
  parameter int PART_W     = 2,
  parameter logic [(1<<SLOT_W)*PART_W-1:0] PART_MAP = '0
) (
  input  logic [SLOT_W-1:0] slot_i,
  output logic [PART_W-1:0] part_o,
  output logic              exists_o
);
  assign part_o   = PART_MAP[slot_i*PART_W +: PART_W];
  assign exists_o = int'(slot_i) < NUM_BLOCKS;
endmodule

// File: rtl/rww_interlock.sv
module rww_interlock
  import rww_pkg::*;
#(
  parameter il_kind_e KIND   = IL_PROG,
  parameter int       ADDR_W = 7,
  parameter int       DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pgm_i,
  input  logic              ers_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              commit_o
);
  logic hold, arm;

  generate
    if (KIND == IL_PROG) begin : g_prog
      assign hold = pgm_i;
      assign arm  = pgm_i;
    end else begin : g_erase
      assign hold = ers_i;
      assign arm  = ers_i & ~pgm_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else if (!hold) begin
      vld_o <= 1'b0;
    end else if (arm && wr_en_i && !vld_o) begin
      vld_o  <= 1'b1;
      addr_o <= wr_addr_i;
      data_o <= wr_data_i;
    end
  end

  // operation ends on the edge that sees its bit low
  assign commit_o = vld_o & ~hold;

  assert_il_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && hold) |=> (vld_o && $stable(addr_o) && $stable(data_o)));
  assert_il_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold |=> !vld_o);
endmodule

// File: rtl/rww_array.sv
module rww_array #(
  parameter int SLOT_W     = 3,
  parameter int WORD_W     = 4,
  parameter int NUM_BLOCKS = 6,
  parameter int DATA_W     = 32,
  parameter logic [DATA_W-1:0] FILL = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [SLOT_W+WORD_W-1:0] rd_addr_i,
  input  logic                     rd_exists_i,
  output logic [DATA_W-1:0]        rd_data_o,
  input  logic                     erase_en_i,
  input  logic [SLOT_W-1:0]        erase_slot_i,
  input  logic                     prog_en_i,
  input  logic [SLOT_W+WORD_W-1:0] prog_addr_i,
  input  logic [DATA_W-1:0]        prog_data_i
);
  localparam int ADDR_W    = SLOT_W + WORD_W;
  localparam int WORDS     = 1 << WORD_W;
  localparam int NUM_WORDS = NUM_BLOCKS * WORDS;

  logic [DATA_W-1:0] mem_q [NUM_WORDS];
  logic [DATA_W-1:0] mem_d [NUM_WORDS];

  always_comb begin
    mem_d = mem_q;
    if (erase_en_i) begin
      for (int w = 0; w < WORDS; w++) begin
        mem_d[{erase_slot_i, WORD_W'(w)}] = '1;
      end
    end
    // program after erase on a shared edge; only clears bits
    if (prog_en_i) mem_d[prog_addr_i] = mem_d[prog_addr_i] & prog_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= '1;
    end else begin
      mem_q <= mem_d;
    end
  end

  assign rd_data_o = rd_exists_i ? mem_q[rd_addr_i] : FILL;

  assert_prog_clears_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_en_i && !erase_en_i) |=> ((mem_q[$past(prog_addr_i)] & ~$past(mem_q[prog_addr_i])) == '0));
endmodule

// File: rtl/rww_flash_ctrl.sv
module rww_flash_ctrl
  import rww_pkg::*;
#(
  parameter int SLOT_W     = 3,
  parameter int WORD_W     = 4,
  parameter int NUM_BLOCKS = 6,
  parameter int DATA_W     = 32,
  parameter int PART_W     = 2,
  parameter logic [(1<<SLOT_W)*PART_W-1:0] PART_MAP = 16'hFA50,
  parameter logic [DATA_W-1:0] FILL = DATA_W'(RWW_FILL),
  localparam int ADDR_W    = SLOT_W + WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pgm_i,
  input  logic              psus_i,
  input  logic              ers_i,
  input  logic              esus_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NUM_BLOCKS-1:0] lock_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_gnt_o,
  output logic              rd_stall_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              interlock_o
);
  localparam int SLOTS = 1 << SLOT_W;

  logic [SLOTS-1:0]  lock_ext;
  logic [PART_W-1:0] rd_part, pg_part, er_part;
  logic              rd_exists, pg_exists, er_exists;
  logic              pg_vld, er_vld, pg_commit, er_commit;
  logic [ADDR_W-1:0] pg_addr, er_addr;
  logic [DATA_W-1:0] pg_data, er_data_unused, rd_word;
  logic              prog_busy, erase_busy, conflict;
  logic              prog_en, erase_en;

  // nonexistent slots behave as permanently locked
  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_lock
      if (s < NUM_BLOCKS) begin : g_real
        assign lock_ext[s] = lock_i[s];
      end else begin : g_void
        assign lock_ext[s] = 1'b1;
      end
    end
  endgenerate

  rww_part_decode #(.SLOT_W(SLOT_W), .NUM_BLOCKS(NUM_BLOCKS), .PART_W(PART_W), .PART_MAP(PART_MAP))
    u_dec_rd (.slot_i(rd_addr_i[ADDR_W-1 -: SLOT_W]), .part_o(rd_part), .exists_o(rd_exists));
  rww_part_decode #(.SLOT_W(SLOT_W), .NUM_BLOCKS(NUM_BLOCKS), .PART_W(PART_W), .PART_MAP(PART_MAP))
    u_dec_pg (.slot_i(pg_addr[ADDR_W-1 -: SLOT_W]), .part_o(pg_part), .exists_o(pg_exists));
  rww_part_decode #(.SLOT_W(SLOT_W), .NUM_BLOCKS(NUM_BLOCKS), .PART_W(PART_W), .PART_MAP(PART_MAP))
    u_dec_er (.slot_i(er_addr[ADDR_W-1 -: SLOT_W]), .part_o(er_part), .exists_o(er_exists));

  rww_interlock #(.KIND(IL_PROG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_il_prog (
    .clk_i, .rst_ni, .pgm_i, .ers_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .vld_o(pg_vld), .addr_o(pg_addr), .data_o(pg_data), .commit_o(pg_commit));
  rww_interlock #(.KIND(IL_ERASE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_il_erase (
    .clk_i, .rst_ni, .pgm_i, .ers_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .vld_o(er_vld), .addr_o(er_addr), .data_o(er_data_unused), .commit_o(er_commit));

  assign prog_busy  = pgm_i & ~psus_i & pg_vld;
  assign erase_busy = ers_i & ~esus_i & ~pgm_i & er_vld;
  assign conflict   = (prog_busy  && rd_part == pg_part) ||
                      (erase_busy && rd_part == er_part);

  assign rd_gnt_o    = rd_req_i & ~conflict;
  assign rd_stall_o  = rd_req_i &  conflict;
  assign interlock_o = pg_vld | er_vld;

  assign prog_en  = pg_commit & pg_exists & ~lock_ext[pg_addr[ADDR_W-1 -: SLOT_W]];
  assign erase_en = er_commit & er_exists & ~lock_ext[er_addr[ADDR_W-1 -: SLOT_W]];

  rww_array #(.SLOT_W(SLOT_W), .WORD_W(WORD_W), .NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W), .FILL(FILL))
    u_array (
      .clk_i, .rst_ni,
      .rd_addr_i, .rd_exists_i(rd_exists), .rd_data_o(rd_word),
      .erase_en_i(erase_en), .erase_slot_i(er_addr[ADDR_W-1 -: SLOT_W]),
      .prog_en_i(prog_en), .prog_addr_i(pg_addr), .prog_data_i(pg_data));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_gnt_o;
      if (rd_gnt_o) rd_data_o <= rd_word;
    end
  end

  assert_gnt_stall_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_gnt_o && rd_stall_o) && ((rd_gnt_o || rd_stall_o) == rd_req_i));
  assert_prog_susp_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgm_i && psus_i && rd_req_i) |-> rd_gnt_o);
  assert_erase_susp_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ers_i && esus_i && !pgm_i && rd_req_i) |-> rd_gnt_o);
  assert_no_il_no_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !interlock_o |-> !rd_stall_o);
  assert_stall_no_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stall_o |=> !rd_valid_o);
  assert_rd_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_gnt_o |=> rd_valid_o);
  assert_fill_word_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_gnt_o && !rd_exists) |=> (rd_data_o == FILL));
endmodule

// File: tb/rww_flash_ctrl_tb.sv
module rww_flash_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FILL = 32'hDEAD_BEEF;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pgm = 0, psus = 0, ers = 0, esus = 0, wr_en = 0, rd_req = 0;
  logic [6:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0] lock = '0;
  logic rd_gnt, rd_stall, rd_valid, interlock;
  logic [31:0] rd_data;

  int n_checks = 0, n_fail = 0;
  logic [31:0] m_mem [96];
  logic m_ilp = 0, m_ile = 0;
  logic [6:0] m_pa = '0, m_ea = '0;
  logic [31:0] m_pd = '0;
  logic last_gnt, last_stall;
  logic [31:0] last_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  rww_flash_ctrl u_dut (
    .clk_i(clk), .rst_ni, .pgm_i(pgm), .psus_i(psus), .ers_i(ers), .esus_i(esus),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .lock_i(lock),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr), .rd_gnt_o(rd_gnt), .rd_stall_o(rd_stall),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .interlock_o(interlock));

  function automatic bit f_exists(logic [6:0] a); return a[6:4] < 3'd6; endfunction
  function automatic logic [1:0] f_part(logic [6:0] a);
    return f_exists(a) ? 2'(a[6:4] >> 1) : 2'd3;
  endfunction
  function automatic bit f_conflict(logic [6:0] a);
    bit pb, eb;
    pb = pgm && !psus && m_ilp;
    eb = ers && !esus && !pgm && m_ile;
    return (pb && f_part(a) == f_part(m_pa)) || (eb && f_part(a) == f_part(m_ea));
  endfunction
  function automatic bit f_unlocked(logic [6:0] a);
    return f_exists(a) && !lock[a[6:4]];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit pc, ec;
    pc = m_ilp && !pgm;
    ec = m_ile && !ers;
    if (ec && f_unlocked(m_ea))
      for (int w = 0; w < 16; w++) m_mem[{m_ea[6:4], 4'(w)}] = '1;
    if (pc && f_unlocked(m_pa)) m_mem[m_pa] = m_mem[m_pa] & m_pd;
    if (!pgm) m_ilp = 0;
    else if (wr_en && !m_ilp) begin m_ilp = 1; m_pa = wr_addr; m_pd = wr_data; end
    if (!ers) m_ile = 0;
    else if (wr_en && !pgm && !m_ile) begin m_ile = 1; m_ea = wr_addr; end
  endtask

  task automatic step();
    bit eg, es;
    string tg, dtg;
    logic [31:0] ed;
    #1;
    eg = 0; es = 0;
    if (rd_req) begin es = f_conflict(rd_addr); eg = !es; end
    if (pgm && psus) tg = "R1";
    else if (ers && esus && !pgm) tg = "R2";
    else if (es) tg = "R4";
    else tg = "R3";
    check(rd_gnt === eg, tg, 32'(rd_gnt), 32'(eg));
    check(rd_stall === es, tg, 32'(rd_stall), 32'(es));
    last_gnt = rd_gnt; last_stall = rd_stall;
    ed = f_exists(rd_addr) ? m_mem[rd_addr] : FILL;
    dtg = f_exists(rd_addr) ? "R10" : "R9";
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(rd_valid === eg, "R10", 32'(rd_valid), 32'(eg));
    if (eg) check(rd_data === ed, dtg, rd_data, ed);
    last_data = rd_data;
    check(interlock === (m_ilp | m_ile), "R6", 32'(interlock), 32'(m_ilp | m_ile));
  endtask

  task automatic rd(input logic [6:0] a);
    rd_req = 1; rd_addr = a; wr_en = 0; step(); rd_req = 0;
  endtask
  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; rd_req = 0; step(); wr_en = 0;
  endtask
  task automatic idle(); rd_req = 0; wr_en = 0; step(); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 96; i++) m_mem[i] = '1;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(rd_valid === 1'b0 && interlock === 1'b0, "R11", {rd_valid, interlock}, 32'd0);
    rst_ni = 1;
    for (int a = 0; a < 128; a++) begin
      rd(7'(a));
      check(last_data === (a < 96 ? 32'hFFFF_FFFF : FILL), "R11", last_data,
            a < 96 ? 32'hFFFF_FFFF : FILL);
    end

    // program in block 0, sibling/other partition reads, suspend
    pgm = 1; idle();
    rd(7'h13); check(last_gnt === 1'b1, "R3", 32'(last_gnt), 32'd1); // no interlock yet
    wr(7'h03, 32'hFFFF_0000);
    check(interlock === 1'b1, "R6", 32'(interlock), 32'd1);
    rd(7'h13); check(last_stall === 1'b1 && last_gnt === 1'b0, "R4", 32'(last_stall), 32'd1);
    rd(7'h23); check(last_gnt === 1'b1, "R3", 32'(last_gnt), 32'd1);
    rd(7'h45); check(last_gnt === 1'b1, "R5", 32'(last_gnt), 32'd1);
    psus = 1;
    rd(7'h03); check(last_gnt === 1'b1, "R1", 32'(last_gnt), 32'd1);
    psus = 0;
    wr(7'h20, 32'h0); // second write ignored
    pgm = 0; idle();
    check(interlock === 1'b0, "R6", 32'(interlock), 32'd0);
    rd(7'h03); check(last_data === 32'hFFFF_0000, "R7", last_data, 32'hFFFF_0000);
    rd(7'h20); check(last_data === 32'hFFFF_FFFF, "R6", last_data, 32'hFFFF_FFFF);

    // bits only go 1->0
    pgm = 1; wr(7'h03, 32'h0000_FFFF); pgm = 0; idle();
    rd(7'h03); check(last_data === 32'h0, "R7", last_data, 32'h0);
    // locked block unchanged
    lock[0] = 1; pgm = 1; wr(7'h04, 32'h0); pgm = 0; idle(); lock[0] = 0;
    rd(7'h04); check(last_data === 32'hFFFF_FFFF, "R7", last_data, 32'hFFFF_FFFF);

    // erase block 0
    ers = 1; wr(7'h07, 32'h0);
    rd(7'h15); check(last_stall === 1'b1, "R4", 32'(last_stall), 32'd1);
    esus = 1;
    rd(7'h15); check(last_gnt === 1'b1, "R2", 32'(last_gnt), 32'd1);
    pgm = 1; rd(7'h15); check(last_gnt === 1'b1, "R3", 32'(last_gnt), 32'd1); pgm = 0;
    esus = 0; ers = 0; idle();
    rd(7'h03); check(last_data === 32'hFFFF_FFFF, "R8", last_data, 32'hFFFF_FFFF);

    // nonexistent block
    pgm = 1; wr(7'h65, 32'h0);
    check(interlock === 1'b1, "R9", 32'(interlock), 32'd1);
    rd(7'h70); check(last_stall === 1'b1, "R9", 32'(last_stall), 32'd1);
    rd(7'h40); check(last_gnt === 1'b1, "R5", 32'(last_gnt), 32'd1);
    pgm = 0; idle();
    rd(7'h65); check(last_data === FILL, "R9", last_data, FILL);

    // constrained random
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(7) == 0) pgm = ~pgm;
      if ($urandom_range(5) == 0) psus = ~psus;
      if ($urandom_range(7) == 0) ers = ~ers;
      if ($urandom_range(5) == 0) esus = ~esus;
      if ($urandom_range(15) == 0) lock[$urandom_range(5)] ^= 1'b1;
      wr_en   = ($urandom_range(3) == 0);
      wr_addr = 7'($urandom);
      wr_data = $urandom | $urandom;
      rd_req  = ($urandom_range(3) != 0);
      rd_addr = ($urandom_range(3) == 0) ? m_pa ^ 7'($urandom_range(31)) : 7'($urandom);
      step();
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule